// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block tracks how many finished operations have asked to be told about their completion, and it drives one interrupt line. The line goes up when either enough completions have built up or a hold-off timer has run for long enough. Software sets both thresholds through a small write port. It reads the outstanding count on a dedicated output. It returns handled completions by writing an acknowledge amount, which lowers the count and restarts the timer.

The time threshold is given in units of 1024 cycles, so the timer is wide enough to reach the largest scaled threshold. The timer stops at its maximum value and does not wrap.

After every acknowledge the interrupt condition is evaluated again. If the remaining count still meets the count threshold, the line rises again at once. This closes the race between an acknowledge and a completion that arrives late.

An enable bit gates only the output line. It has separate set and clear write codes. Counting and timing carry on while the enable is off.

Top module: `cmpl_irq_coalescer`

## Requirements
- R1: A cycle with `cmpl_valid` and `cmpl_notify` both high adds one to `done_count`. The count is visible on the output after that clock edge.
- R2: A completion with `cmpl_notify` low leaves `done_count` unchanged.
- R3: An acknowledge write subtracts `wr_data` from the count, and the count never goes below zero. A notified completion in the same cycle also applies, so the new count is old + 1 − acknowledged amount, floored at 0.
- R4: While `done_count` is zero, the hold-off timer stays at zero. The cycle after the count is zero, `irq_o` is low.
- R5: While the count is nonzero, the timer advances by one each cycle and stops at its maximum. An acknowledge write or a count load write returns it to zero.
- R6: The interrupt condition holds when count ≥ count threshold. A count threshold of 0 behaves as 1.
- R7: The interrupt condition holds when the timer ≥ time threshold × 1024. A time threshold of 0 turns this criterion off.
- R8: After an acknowledge, if the remaining count still meets the count threshold, `irq_o` is high again on the next cycle, even though the timer is zero.
- R9: `irq_o` is high only while the enable is on. The enable-set code with `wr_data[0]`=1 turns it on, and the enable-clear code with `wr_data[0]`=1 turns it off. Counting continues while it is off.
- R10: A count load write replaces `done_count` with `wr_data` and restarts the timer.
- R11: `irq_o` is a registered level. It is high in the cycle after the edge at which enable and condition were both true, and low in the cycle after they stop holding.
- R12: Reset clears the count, the timer, the enable and both thresholds, so `irq_o` is low.
- R13: The `wr_sel` codes are: 0 count threshold, 1 time threshold (low 16 bits of `wr_data`), 2 acknowledge, 3 enable set, 4 enable clear, 5 count load. The codes 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_valid | input | 1 | One operation completed this cycle |
| cmpl_notify | input | 1 | The completing operation asked for notification |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code (see R13) |
| wr_data | input | CNT_W (20) | Write value |
| done_count | output | CNT_W (20) | Current outstanding count |
| irq_o | output | 1 | Coalesced interrupt level |

## Verification
The assertions assume that software never lets the count pass its 20-bit limit. They also assume `wr_sel` holds one code per cycle, so a set and a clear of the enable never arrive together. The stimulus meets both assumptions: it keeps fewer than a handful of completions outstanding, it issues exactly one write per step, and it applies each completion pulse in the same step as at most one acknowledge. The bench uses the long time-threshold wait to check the timer criterion. It never holds the timer against its 26-bit ceiling, so saturation is covered only by the timer assertion.

// File: rtl/coal_pkg.sv
package coal_pkg;
   typedef enum logic [2:0] {
      SEL_NUM_THR  = 3'd0,
      SEL_TIME_THR = 3'd1,
      SEL_ACK      = 3'd2,
      SEL_ENA_SET  = 3'd3,
      SEL_ENA_CLR  = 3'd4,
      SEL_CNT_LOAD = 3'd5
   } coal_sel_e;
endpackage

// File: rtl/coal_cfg_regs.sv
module coal_cfg_regs
   import coal_pkg::*;
#(
   parameter int CNT_W  = 20,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  num_thr,
   output logic [TIME_W-1:0] time_thr,
   output logic              ena
);
   timeunit 1ns; timeprecision 100ps;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         num_thr  <= '0;
         time_thr <= '0;
         ena      <= 1'b0;
      end else if (wr_en) begin
         case (coal_sel_e'(wr_sel))
            SEL_NUM_THR:  num_thr  <= wr_data;
            SEL_TIME_THR: time_thr <= wr_data[TIME_W-1:0];
            SEL_ENA_SET:  if (wr_data[0]) ena <= 1'b1;
            SEL_ENA_CLR:  if (wr_data[0]) ena <= 1'b0;
            default: ;
         endcase
      end
   end

   // an enable-set write must leave the enable on
   p_ena_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'(SEL_ENA_SET) && wr_data[0]) |=> ena);
   p_ena_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'(SEL_ENA_CLR) && wr_data[0]) |=> !ena);
endmodule

// File: rtl/coal_done_counter.sv
module coal_done_counter #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             ack_en,
   input  logic [CNT_W-1:0] ack_val,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count_q
);
   timeunit 1ns; timeprecision 100ps;

   localparam int EXT_W = CNT_W + 1;

   logic [EXT_W-1:0] sum_ext, dec_ext, diff_ext;
   logic [CNT_W-1:0] count_d;

   always_comb begin
      sum_ext  = {1'b0, count_q} + EXT_W'(inc_i);
      dec_ext  = ack_en ? {1'b0, ack_val} : '0;
      diff_ext = sum_ext - dec_ext;
      if (load_en)
         count_d = load_val;
      else if (sum_ext <= dec_ext)
         count_d = '0;
      else if (diff_ext[CNT_W])
         count_d = '1;                     // hold at the ceiling
      else
         count_d = diff_ext[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_d;
   end

   p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !ack_en && !load_en && count_q != '1)
      |=> count_q == $past(count_q) + CNT_W'(1));
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !ack_en && !load_en) |=> $stable(count_q));
   p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_en && !load_en && ({1'b0, ack_val} >= {1'b0, count_q} + EXT_W'(inc_i)))
      |=> count_q == '0);
   p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> count_q == $past(load_val));
endmodule

// File: rtl/coal_holdoff_timer.sv
module coal_holdoff_timer #(
   parameter int CNT_W = 20,
   parameter int TMR_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic             restart_i,
   output logic [TMR_W-1:0] timer_q
);
   timeunit 1ns; timeprecision 100ps;

   always_ff @(posedge clk) begin
      if (!rst_n)
         timer_q <= '0;
      else if (restart_i || count_i == '0)
         timer_q <= '0;
      else if (timer_q != '1)
         timer_q <= timer_q + TMR_W'(1);
   end

   p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (count_i == '0) |=> timer_q == '0);
   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> timer_q == '0);
   p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (count_i != '0 && !restart_i && timer_q != '1)
      |=> timer_q == $past(timer_q) + TMR_W'(1));
   p_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (count_i != '0 && !restart_i && timer_q == '1) |=> timer_q == '1);
endmodule

// File: rtl/cmpl_irq_coalescer.sv
module cmpl_irq_coalescer
   import coal_pkg::*;
#(
   parameter int CNT_W        = 20,
   parameter int TIME_W       = 16,
   parameter int SCALE_LOG2   = 10,
   parameter bit TIME_CRIT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmpl_valid,
   input  logic             cmpl_notify,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] done_count,
   output logic             irq_o
);
   timeunit 1ns; timeprecision 100ps;

   localparam int TMR_W = TIME_W + SCALE_LOG2;

   if (TIME_W > CNT_W) begin : g_bad_time_w
      $error("TIME_W must not exceed CNT_W");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("CNT_W must be at least 2");
   end
   if (TMR_W > 62) begin : g_bad_tmr_w
      $error("scaled timer too wide");
   end

   logic [CNT_W-1:0]  num_thr;
   logic [TIME_W-1:0] time_thr;
   logic              ena;
   logic [TMR_W-1:0]  timer;
   logic              ack_en, load_en, inc;

   assign inc     = cmpl_valid & cmpl_notify;
   assign ack_en  = wr_en && (wr_sel == 3'(SEL_ACK));
   assign load_en = wr_en && (wr_sel == 3'(SEL_CNT_LOAD));

   coal_cfg_regs #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .num_thr(num_thr), .time_thr(time_thr), .ena(ena));

   coal_done_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc_i(inc), .ack_en(ack_en), .ack_val(wr_data),
      .load_en(load_en), .load_val(wr_data), .count_q(done_count));

   coal_holdoff_timer #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .count_i(done_count),
      .restart_i(ack_en | load_en), .timer_q(timer));

   logic [CNT_W-1:0] eff_num;
   logic             cnt_hit, time_hit, fire;

   assign eff_num = (num_thr == '0) ? CNT_W'(1) : num_thr;
   assign cnt_hit = done_count >= eff_num;

   if (TIME_CRIT_EN) begin : g_time_crit
      logic [TMR_W-1:0] time_lim;
      assign time_lim = TMR_W'(time_thr) << SCALE_LOG2;
      assign time_hit = (time_thr != '0) && (timer >= time_lim);
   end else begin : g_no_time_crit
      assign time_hit = 1'b0;
   end

   assign fire = (done_count != '0) && (cnt_hit || time_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= ena & fire;
   end

   p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_count == '0) |=> !irq_o);
   p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ena |=> !irq_o);
   p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ena && done_count != '0 && done_count >= num_thr) |=> irq_o);
   p_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (TIME_CRIT_EN && ena && done_count != '0 && time_thr != '0 &&
       timer >= (TMR_W'(time_thr) << SCALE_LOG2)) |=> irq_o);
   p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ena && $past(ack_en) && done_count >= eff_num) |=> irq_o);
endmodule

// File: tb/cmpl_irq_coalescer_test.sv
module cmpl_irq_coalescer_test;
   timeunit 1ns; timeprecision 100ps;

   localparam int CW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmpl_valid = 1'b0, cmpl_notify = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_sel = 3'd0;
   logic [CW-1:0] wr_data = '0;
   logic [CW-1:0] done_count;
   logic          irq_o;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cmpl_irq_coalescer uut (
      .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_notify(cmpl_notify),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .done_count(done_count), .irq_o(irq_o));

   typedef struct packed {
      logic          we;
      logic [2:0]    sel;
      logic [CW-1:0] data;
      logic          cv;
      logic          cn;
      logic [CW-1:0] exp_cnt;
      logic          exp_irq;
   } vec_t;

   // select codes: 0 num thr, 1 time thr, 2 ack, 3 ena set, 4 ena clr, 5 load
   localparam vec_t VECS[27] = '{
      '{1'b1, 3'd0, 20'd3, 1'b0, 1'b0, 20'd0, 1'b0}, // num thr 3
      '{1'b1, 3'd3, 20'd1, 1'b0, 1'b0, 20'd0, 1'b0}, // enable on
      '{1'b0, 3'd0, 20'd0, 1'b1, 1'b1, 20'd1, 1'b0}, // R1
      '{1'b0, 3'd0, 20'd0, 1'b1, 1'b0, 20'd1, 1'b0}, // R2 no notify
      '{1'b0, 3'd0, 20'd0, 1'b1, 1'b1, 20'd2, 1'b0},
      '{1'b0, 3'd0, 20'd0, 1'b1, 1'b1, 20'd3, 1'b0},
      '{1'b0, 3'd0, 20'd0, 1'b0, 1'b0, 20'd3, 1'b1}, // R6 count 3 >= 3
      '{1'b1, 3'd2, 20'd1, 1'b0, 1'b0, 20'd2, 1'b1}, // ack 1
      '{1'b0, 3'd0, 20'd0, 1'b0, 1'b0, 20'd2, 1'b0}, // R11 drop
      '{1'b1, 3'd2, 20'd1, 1'b1, 1'b1, 20'd2, 1'b0}, // R3 both
      '{1'b1, 3'd2, 20'd5, 1'b0, 1'b0, 20'd0, 1'b0}, // R3 floor
      '{1'b0, 3'd0, 20'd0, 1'b0, 1'b0, 20'd0, 1'b0}, // R4
      '{1'b1, 3'd0, 20'd0, 1'b0, 1'b0, 20'd0, 1'b0}, // num thr 0 acts as 1
      '{1'b0, 3'd0, 20'd0, 1'b1, 1'b1, 20'd1, 1'b0},
      '{1'b0, 3'd0, 20'd0, 1'b0, 1'b0, 20'd1, 1'b1}, // R6
      '{1'b1, 3'd4, 20'd1, 1'b0, 1'b0, 20'd1, 1'b1}, // enable off
      '{1'b0, 3'd0, 20'd0, 1'b0, 1'b0, 20'd1, 1'b0}, // R9 gated
      '{1'b0, 3'd0, 20'd0, 1'b1, 1'b1, 20'd2, 1'b0}, // R9 still counts
      '{1'b1, 3'd3, 20'd1, 1'b0, 1'b0, 20'd2, 1'b0},
      '{1'b0, 3'd0, 20'd0, 1'b0, 1'b0, 20'd2, 1'b1},
      '{1'b1, 3'd5, 20'd0, 1'b0, 1'b0, 20'd0, 1'b1}, // R10 load 0
      '{1'b0, 3'd0, 20'd0, 1'b0, 1'b0, 20'd0, 1'b0},
      '{1'b1, 3'd5, 20'd5, 1'b0, 1'b0, 20'd5, 1'b0}, // R10 load 5
      '{1'b1, 3'd2, 20'd2, 1'b0, 1'b0, 20'd3, 1'b1}, // ack 2
      '{1'b0, 3'd0, 20'd0, 1'b0, 1'b0, 20'd3, 1'b1}, // R8 re-fires
      '{1'b1, 3'd2, 20'd3, 1'b0, 1'b0, 20'd0, 1'b1},
      '{1'b0, 3'd0, 20'd0, 1'b0, 1'b0, 20'd0, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic we, input logic [2:0] sel, input logic [CW-1:0] d,
                       input logic cv, input logic cn);
      wr_en = we; wr_sel = sel; wr_data = d; cmpl_valid = cv; cmpl_notify = cn;
      @(posedge clk); #1;
      wr_en = 1'b0; wr_sel = 3'd0; wr_data = '0; cmpl_valid = 1'b0; cmpl_notify = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      check("R12 count after reset", 32'(done_count), 0);
      check("R12 irq after reset", 32'(irq_o), 0);

      for (int k = 0; k < 27; k++) begin
         step(VECS[k].we, VECS[k].sel, VECS[k].data, VECS[k].cv, VECS[k].cn);
         check($sformatf("table step %0d count (R1,R2,R3,R10)", k),
               32'(done_count), 32'(VECS[k].exp_cnt));
         check($sformatf("table step %0d irq (R4,R6,R8,R9,R11)", k),
               32'(irq_o), 32'(VECS[k].exp_irq));
      end

      // R7: time threshold of 1 -> fires after 1024 cycles with count below num thr
      step(1'b1, 3'd0, 20'd100, 1'b0, 1'b0);
      step(1'b1, 3'd1, 20'd1, 1'b0, 1'b0);
      step(1'b0, 3'd0, 20'd0, 1'b1, 1'b1);
      idle(1024);
      check("R7 irq one cycle before time limit", 32'(irq_o), 0);
      idle(1);
      check("R7 irq at time limit", 32'(irq_o), 1);
      // R5: ack of zero restarts the timer
      step(1'b1, 3'd2, 20'd0, 1'b0, 1'b0);
      check("R5 irq just after ack edge", 32'(irq_o), 1);
      idle(1);
      check("R5 irq after timer restart", 32'(irq_o), 0);
      check("R5 count kept by zero ack", 32'(done_count), 1);
      // R7: time threshold 0 disables the time criterion
      step(1'b1, 3'd1, 20'd0, 1'b0, 1'b0);
      idle(2000);
      check("R7 time criterion off", 32'(irq_o), 0);
      // R13: unused select code has no effect
      step(1'b1, 3'd6, 20'hFFFFF, 1'b0, 1'b0);
      idle(1);
      check("R13 code 6 leaves count", 32'(done_count), 1);
      check("R13 code 6 leaves irq", 32'(irq_o), 0);
      // R12: reset mid-run clears state
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
      check("R12 count after second reset", 32'(done_count), 0);
      step(1'b0, 3'd0, 20'd0, 1'b1, 1'b1);
      idle(2);
      check("R12 enable off after reset", 32'(irq_o), 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule